// File: doc/BRIEF.md
# Audio Port Register and Sample FIFO Front-End

This block is the register and buffering front-end of a serial digital audio port. A host reaches it through an APB-style access port: four word registers (control, event, FIFO thresholds, live status) and one data window through which 24-bit audio words enter or leave a sample FIFO. In transmit mode the host writes words into the window and the serial engine drains them. In receive mode the engine fills the FIFO and the host reads the words out of the window. The line coding and clock recovery sit in the engine, outside this block.

Ten event conditions feed sticky event bits. Each bit sets on the rising edge of its condition and clears when the host writes zero to it. A mask bit at the same position in the control word selects which events may raise the interrupt output, and a global enable gates the whole interrupt. Two control bits act as self-restoring active-low soft resets. One returns the configuration registers to their defaults. The other empties the FIFO and leaves the thresholds alone.

Top module: `audfe_top`

## Requirements
- R1: After reset, control reads 0x0000_0500, thresholds read 0x001C_0004 (almost-empty 4, almost-full 28), the event register reads 0, status reads 0x0300_0000 (empty and almost-empty live, level 0), and irq is low.
- R2: Register offsets are control 0x000, event 0x004, thresholds 0x008, status 0x00C, data window 0x100. The threshold word keeps only bits [5:0] (almost-empty level) and [21:16] (almost-full level). Writes to status have no effect.
- R3: Control bit 12 = 1 selects transmit. Window writes then push pwdata[23:0], the engine pops them in order on eng_rd_data, and status bits [5:0] give the FIFO level.
- R4: Control bit 12 = 0 selects receive. Engine pushes are read back in order from the window (read data in bits [23:0], upper bits zero).
- R5: Live status bit 25 (almost empty) is set when level ≤ almost-empty level. Bit 27 (almost full) is set when level ≥ almost-full level. Bit 24 is empty and bit 26 is full.
- R6: A window write while the FIFO is full is dropped and sets event bit 23 (overrun). A window read or engine pop while it is empty returns zero and sets event bit 22 (underrun).
- R7: Event bits 21..30 (parity, underrun, overrun, empty, almost empty, full, almost full, sync, lock, block begin) set on the rising edge of their condition and hold until written with 0. Writing 1 leaves a bit unchanged.
- R8: irq is high only when control bit 31 is set and some event bit is set whose mask bit at the same position in control is also set.
- R9: A control write with bit 8 = 0 restores control, thresholds and events to their reset values and leaves the FIFO contents intact. Bit 8 reads back as 1.
- R10: A control write with bit 10 = 0 (bit 8 = 1) empties the FIFO and keeps the thresholds. Bit 10 reads back as 1.
- R11: While control bit 9 (engine run) is 0, engine pushes, pops and engine event inputs have no effect.
- R12: Status bit 31 gives the channel of the last word that entered the FIFO (1 = left). Transmit words alternate, with the first after a FIFO reset being left. Receive words take eng_wr_left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Access select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| eng_run | output | 1 | Engine run (control bit 9) |
| eng_tx | output | 1 | Direction to engine (control bit 12) |
| eng_pop | input | 1 | Engine takes the FIFO head (transmit) |
| eng_rd_data | output | 24 | FIFO head word |
| eng_push | input | 1 | Engine writes a word (receive) |
| eng_wr_data | input | 24 | Received word |
| eng_wr_left | input | 1 | Received word is left channel |
| eng_parity_err | input | 1 | Parity error condition |
| eng_sync_err | input | 1 | Sync error condition |
| eng_lock | input | 1 | Receiver locked condition |
| eng_block_begin | input | 1 | Block start condition |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is the overrun at a full FIFO. The stimulus gets there by filling all 32 entries through the window and then writing once more. Draining the FIFO then shows in order that the extra word never entered. The edge-set event bits are also awkward, because they fire only on transitions. The stimulus therefore walks the level down through the almost-empty threshold and to empty, then clears the bits one at a time to prove that writing 1 keeps a bit. The soft resets are exercised with data already in the FIFO, to show that each touches only its own state.

// File: rtl/audfe_pkg.sv
package audfe_pkg;
  localparam int REG_W = 32;
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_EVT  = 12'h004;
  localparam logic [11:0] A_THR  = 12'h008;
  localparam logic [11:0] A_STAT = 12'h00C;
  localparam logic [11:0] A_DATA = 12'h100;

  localparam int CB_REGRST_N  = 8;
  localparam int CB_RUN       = 9;
  localparam int CB_FIFORST_N = 10;
  localparam int CB_TX        = 12;
  localparam int CB_GIE       = 31;
  localparam int EVT_LO       = 21;
  localparam int N_EVT        = 10;
  localparam int THR_AF_LO    = 16;

  localparam int EV_PAR  = 0;
  localparam int EV_UND  = 1;
  localparam int EV_OVR  = 2;
  localparam int EV_EMP  = 3;
  localparam int EV_AE   = 4;
  localparam int EV_FULL = 5;
  localparam int EV_AF   = 6;
  localparam int EV_SYNC = 7;
  localparam int EV_LOCK = 8;
  localparam int EV_BLK  = 9;

  localparam logic [REG_W-1:0] CTRL_FIXED   = 32'h0000_0500;
  localparam logic [REG_W-1:0] CTRL_WMASK   = 32'hFFE0_1200;
  localparam logic [REG_W-1:0] CTRL_DEFAULT = CTRL_FIXED;
endpackage

// File: rtl/audfe_fifo.sv
module audfe_fifo #(
  parameter int DW    = 24,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;

  assign full  = (lvl_q == LW'(DEPTH));
  assign empty = (lvl_q == '0);
  assign level = lvl_q;
  assign head  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (push) wr_d = wr_q + 1'b1;
      if (pop)  rd_d = rd_q + 1'b1;
      if (push && !pop) lvl_d = lvl_q + 1'b1;
      else if (pop && !push) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_q] <= push_data;
  end
endmodule

// File: rtl/audfe_events.sv
module audfe_events #(
  parameter int N = 10,
  parameter logic [N-1:0] PREV_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_clr,
  input  logic [N-1:0] cond,
  input  logic         wr_en,
  input  logic [N-1:0] wr_keep,
  input  logic [N-1:0] mask_en,
  input  logic         gie,
  output logic [N-1:0] evt,
  output logic         irq
);
  logic [N-1:0] evt_q, evt_d, prev_q, rise;

  assign rise = cond & ~prev_q;

  always_comb begin
    if (sw_clr) evt_d = '0;
    else if (wr_en) evt_d = (evt_q & wr_keep) | rise;
    else evt_d = evt_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      prev_q <= PREV_RST;
    end else begin
      evt_q  <= evt_d;
      prev_q <= cond;
    end
  end

  assign evt = evt_q;
  assign irq = gie & (|(evt_q & mask_en));
endmodule

// File: rtl/audfe_top.sv
module audfe_top
  import audfe_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DW     = 24,
  parameter int DEPTH  = 32,
  parameter int AE_DEF = 4,
  parameter int AF_DEF = 28,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              eng_run,
  output logic              eng_tx,
  input  logic              eng_pop,
  output logic [DW-1:0]     eng_rd_data,
  input  logic              eng_push,
  input  logic [DW-1:0]     eng_wr_data,
  input  logic              eng_wr_left,
  input  logic              eng_parity_err,
  input  logic              eng_sync_err,
  input  logic              eng_lock,
  input  logic              eng_block_begin,
  output logic              irq
);
  localparam logic [N_EVT-1:0] EV_RST = N_EVT'((1 << EV_EMP) | (1 << EV_AE));

  logic acc, wr, rd;
  logic sel_ctrl, sel_evt, sel_thr, sel_stat, sel_data;
  logic [31:0] ctrl_q, ctrl_d;
  logic [LW-1:0] ae_q, ae_d, af_q, af_d;
  logic reg_rst, fifo_clr;
  logic tx, run;
  logic full, empty;
  logic [LW-1:0] level;
  logic [DW-1:0] head;
  logic apb_push, apb_ovr, apb_pop, apb_und;
  logic e_push, e_ovr, e_pop, e_und;
  logic push, pop;
  logic [DW-1:0] push_data;
  logic last_left_q, last_left_d, next_left_q, next_left_d;
  logic [N_EVT-1:0] cond, evt_q;
  logic [31:0] stat_w, evt_w, thr_w;

  assign acc      = psel & penable;
  assign wr       = acc & pwrite;
  assign rd       = acc & ~pwrite;
  assign sel_ctrl = (paddr == ADDR_W'(A_CTRL));
  assign sel_evt  = (paddr == ADDR_W'(A_EVT));
  assign sel_thr  = (paddr == ADDR_W'(A_THR));
  assign sel_stat = (paddr == ADDR_W'(A_STAT));
  assign sel_data = (paddr == ADDR_W'(A_DATA));

  assign reg_rst  = wr & sel_ctrl & ~pwdata[CB_REGRST_N];
  assign fifo_clr = wr & sel_ctrl & pwdata[CB_REGRST_N] & ~pwdata[CB_FIFORST_N];

  assign tx      = ctrl_q[CB_TX];
  assign run     = ctrl_q[CB_RUN];
  assign eng_tx  = tx;
  assign eng_run = run;

  // register next state
  always_comb begin
    ctrl_d = ctrl_q;
    ae_d   = ae_q;
    af_d   = af_q;
    if (reg_rst) begin
      ctrl_d = CTRL_DEFAULT;
      ae_d   = LW'(AE_DEF);
      af_d   = LW'(AF_DEF);
    end else begin
      if (wr && sel_ctrl) ctrl_d = (pwdata & CTRL_WMASK) | CTRL_FIXED;
      if (wr && sel_thr) begin
        ae_d = pwdata[LW-1:0];
        af_d = pwdata[THR_AF_LO +: LW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_DEFAULT;
      ae_q   <= LW'(AE_DEF);
      af_q   <= LW'(AF_DEF);
    end else begin
      ctrl_q <= ctrl_d;
      ae_q   <= ae_d;
      af_q   <= af_d;
    end
  end

  // FIFO access arbitration
  assign apb_push = wr & sel_data & tx & ~full;
  assign apb_ovr  = wr & sel_data & tx & full;
  assign apb_pop  = rd & sel_data & ~tx & ~empty;
  assign apb_und  = rd & sel_data & ~tx & empty;
  assign e_pop    = eng_pop & run & tx & ~empty;
  assign e_und    = eng_pop & run & tx & empty;
  assign e_push   = eng_push & run & ~tx & ~full;
  assign e_ovr    = eng_push & run & ~tx & full;
  assign push      = apb_push | e_push;
  assign pop       = apb_pop | e_pop;
  assign push_data = tx ? pwdata[DW-1:0] : eng_wr_data;

  audfe_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(push), .push_data(push_data), .pop(pop),
    .head(head), .level(level), .full(full), .empty(empty)
  );
  assign eng_rd_data = head;

  // channel tracking
  always_comb begin
    last_left_d = last_left_q;
    next_left_d = next_left_q;
    if (fifo_clr) begin
      last_left_d = 1'b0;
      next_left_d = 1'b1;
    end else if (apb_push) begin
      last_left_d = next_left_q;
      next_left_d = ~next_left_q;
    end else if (e_push) begin
      last_left_d = eng_wr_left;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_left_q <= 1'b0;
      next_left_q <= 1'b1;
    end else begin
      last_left_q <= last_left_d;
      next_left_q <= next_left_d;
    end
  end

  // live conditions
  always_comb begin
    cond          = '0;
    cond[EV_PAR]  = run & eng_parity_err;
    cond[EV_UND]  = apb_und | e_und;
    cond[EV_OVR]  = apb_ovr | e_ovr;
    cond[EV_EMP]  = empty;
    cond[EV_AE]   = (level <= ae_q);
    cond[EV_FULL] = full;
    cond[EV_AF]   = (level >= af_q);
    cond[EV_SYNC] = run & eng_sync_err;
    cond[EV_LOCK] = run & eng_lock;
    cond[EV_BLK]  = run & eng_block_begin;
  end

  audfe_events #(.N(N_EVT), .PREV_RST(EV_RST)) i_events (
    .clk(clk), .rst_n(rst_n), .sw_clr(reg_rst), .cond(cond),
    .wr_en(wr & sel_evt), .wr_keep(pwdata[EVT_LO +: N_EVT]),
    .mask_en(ctrl_q[EVT_LO +: N_EVT]), .gie(ctrl_q[CB_GIE]),
    .evt(evt_q), .irq(irq)
  );

  // read mux
  always_comb begin
    stat_w = '0;
    stat_w[LW-1:0] = level;
    stat_w[EVT_LO +: N_EVT] = cond;
    stat_w[31] = last_left_q;
    evt_w = '0;
    evt_w[EVT_LO +: N_EVT] = evt_q;
    thr_w = '0;
    thr_w[LW-1:0] = ae_q;
    thr_w[THR_AF_LO +: LW] = af_q;
    prdata = '0;
    if (sel_ctrl) prdata = ctrl_q;
    else if (sel_evt) prdata = evt_w;
    else if (sel_thr) prdata = thr_w;
    else if (sel_stat) prdata = stat_w;
    else if (sel_data && !tx && !empty) prdata = {{(32-DW){1'b0}}, head};
  end
endmodule

// File: rtl/audfe_chk.sv
module audfe_chk
  import audfe_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc,
  input logic             reg_rst,
  input logic             fifo_clr,
  input logic             run,
  input logic             ovr,
  input logic             evt_wr,
  input logic [LW-1:0]    level,
  input logic [N_EVT-1:0] evt,
  input logic [31:0]      ctrl,
  input logic             irq
);
  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  p_overrun_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> evt[EV_OVR]);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_wr && !reg_rst) |=> ((evt & $past(evt)) == $past(evt)));

  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt != '0));

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rst |=> (ctrl == CTRL_DEFAULT && evt == '0));

  p_fifo_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (level == '0));

  p_idle_engine_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !acc) |=> $stable(level));
endmodule

bind audfe_top audfe_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .acc(acc), .reg_rst(reg_rst),
  .fifo_clr(fifo_clr), .run(run), .ovr(apb_ovr | e_ovr),
  .evt_wr(wr & sel_evt), .level(level), .evt(evt_q),
  .ctrl(ctrl_q), .irq(irq)
);

// File: tb/test_audfe_top.sv
module test_audfe_top;
  logic clk = 1'b0;
  logic rst_n, psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic eng_run, eng_tx, eng_pop, eng_push, eng_wr_left, irq;
  logic [23:0] eng_rd_data, eng_wr_data;
  logic eng_parity_err, eng_sync_err, eng_lock, eng_block_begin;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  logic [31:0] rv;

  always #2 clk = ~clk;

  audfe_top i_audfe_top (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .eng_run(eng_run),
    .eng_tx(eng_tx), .eng_pop(eng_pop), .eng_rd_data(eng_rd_data),
    .eng_push(eng_push), .eng_wr_data(eng_wr_data), .eng_wr_left(eng_wr_left),
    .eng_parity_err(eng_parity_err), .eng_sync_err(eng_sync_err),
    .eng_lock(eng_lock), .eng_block_begin(eng_block_begin), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  // driver: host write into the window, expected word queued when accepted
  task automatic host_push(input logic [23:0] w, input bit accepted);
    apb_write(12'h100, {8'hA5, w});
    if (accepted) exp_q.push_back(w);
  endtask

  // monitor for transmit: engine takes head, compared to scoreboard
  task automatic eng_take(input string req);
    logic [23:0] e;
    @(negedge clk);
    eng_pop = 1;
    #1 e = exp_q.pop_front();
    chk(req, {8'h0, eng_rd_data}, {8'h0, e});
    @(negedge clk);
    eng_pop = 0;
  endtask

  task automatic eng_give(input logic [23:0] w, input logic left, input bit accepted);
    @(negedge clk);
    eng_push = 1; eng_wr_data = w; eng_wr_left = left;
    if (accepted) exp_q.push_back(w);
    @(negedge clk);
    eng_push = 0;
  endtask

  // monitor for receive: host reads window, compared to scoreboard
  task automatic host_take(input string req);
    logic [31:0] d;
    logic [23:0] e;
    apb_read(12'h100, d);
    e = exp_q.pop_front();
    chk(req, d, {8'h0, e});
  endtask

  task automatic pulse_parity;
    @(negedge clk); eng_parity_err = 1;
    @(negedge clk); eng_parity_err = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    eng_pop = 0; eng_push = 0; eng_wr_data = '0; eng_wr_left = 0;
    eng_parity_err = 0; eng_sync_err = 0; eng_lock = 0; eng_block_begin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    apb_read(12'h000, rv); chk("R1 ctrl", rv, 32'h0000_0500);
    apb_read(12'h008, rv); chk("R1 thr", rv, 32'h001C_0004);
    apb_read(12'h004, rv); chk("R1 evt", rv, 32'h0);
    apb_read(12'h00C, rv); chk("R1 stat", rv, 32'h0300_0000);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R2 decode and field widths, status read-only
    apb_write(12'h008, 32'hFFFF_FFFF);
    apb_read(12'h008, rv); chk("R2 thr fields", rv, 32'h003F_003F);
    apb_write(12'h008, 32'h0014_0003);
    apb_read(12'h008, rv); chk("R2 thr", rv, 32'h0014_0003);
    apb_write(12'h00C, 32'hFFFF_FFFF);
    apb_read(12'h00C, rv); chk("R2 stat ro", rv, 32'h0300_0000);

    // R3 transmit path
    apb_write(12'h000, 32'h0000_1700);
    apb_read(12'h000, rv); chk("R3 ctrl", rv, 32'h0000_1700);
    for (int i = 1; i <= 5; i++) host_push(24'h10_0001 * i, 1);
    apb_read(12'h00C, rv); chk("R3 R12 stat level", rv, 32'h8000_0005);
    for (int i = 0; i < 5; i++) eng_take("R3 tx order");

    // R7 edge-set, write-0 clear, write-1 keep
    apb_read(12'h004, rv); chk("R7 edges", rv, 32'h0300_0000);
    apb_write(12'h004, 32'hFDFF_FFFF);
    apb_read(12'h004, rv); chk("R7 keep", rv, 32'h0100_0000);
    apb_write(12'h004, 32'h0);
    apb_read(12'h004, rv); chk("R7 clear", rv, 32'h0);

    // R6 underrun on engine pop while empty
    @(negedge clk); eng_pop = 1; @(negedge clk); eng_pop = 0;
    apb_read(12'h004, rv); chk("R6 underrun", rv, 32'h0040_0000);
    apb_write(12'h004, 32'h0);

    // R6 overrun at full, R5 flags
    for (int i = 0; i < 32; i++) host_push(24'h00_0100 + 24'(i), 1);
    host_push(24'hBAD0BA, 0);
    apb_read(12'h00C, rv); chk("R5 R6 full stat", rv & 32'h7FFF_FFFF, 32'h0C00_0020);
    apb_read(12'h004, rv); chk("R6 overrun events", rv, 32'h0C80_0000);
    for (int i = 0; i < 32; i++) eng_take("R6 dropped word absent");
    apb_read(12'h004, rv); chk("R5 drain events", rv, 32'h0F80_0000);
    apb_write(12'h004, 32'h0);

    // R8 interrupt gating
    @(negedge clk); eng_pop = 1; @(negedge clk); eng_pop = 0;
    apb_write(12'h000, 32'h0040_1700);
    chk("R8 no gie", {31'h0, irq}, 32'h0);
    apb_write(12'h000, 32'h8040_1700);
    chk("R8 irq on", {31'h0, irq}, 32'h1);
    apb_write(12'h000, 32'h8000_1700);
    chk("R8 masked", {31'h0, irq}, 32'h0);
    apb_write(12'h000, 32'h8040_1700);
    apb_write(12'h004, 32'h0);
    chk("R8 cleared", {31'h0, irq}, 32'h0);
    apb_write(12'h000, 32'h0000_1700);

    // R10 FIFO pointer reset
    for (int i = 0; i < 3; i++) host_push(24'h33_0000 + 24'(i), 1);
    apb_write(12'h000, 32'h0000_1300);
    exp_q.delete();
    apb_read(12'h000, rv); chk("R10 ctrl restore", rv, 32'h0000_1700);
    apb_read(12'h00C, rv); chk("R10 empty", rv, 32'h0300_0000);
    apb_read(12'h008, rv); chk("R10 thr kept", rv, 32'h0014_0003);

    // R12 channel alternation after FIFO reset
    host_push(24'h0000AA, 1);
    apb_read(12'h00C, rv); chk("R12 left", rv, 32'h8200_0001);
    host_push(24'h0000BB, 1);
    apb_read(12'h00C, rv); chk("R12 right", rv, 32'h0200_0002);
    eng_take("R12 drain");
    eng_take("R12 drain");

    // R4 receive path
    apb_write(12'h000, 32'h0000_0700);
    apb_write(12'h004, 32'h0);
    eng_give(24'hC0FFEE, 1, 1);
    eng_give(24'h123456, 1, 1);
    eng_give(24'hFEDCBA, 0, 1);
    apb_read(12'h00C, rv); chk("R4 R12 rx stat", rv, 32'h0200_0003);
    for (int i = 0; i < 3; i++) host_take("R4 rx order");
    apb_read(12'h100, rv); chk("R6 empty read zero", rv, 32'h0);
    apb_read(12'h004, rv); chk("R6 rx underrun", rv & 32'h0040_0000, 32'h0040_0000);

    // R11 engine stopped
    apb_write(12'h000, 32'h0000_0500);
    apb_write(12'h004, 32'h0);
    eng_give(24'h777777, 0, 0);
    apb_read(12'h00C, rv); chk("R11 push ignored", rv, 32'h0300_0000);
    pulse_parity();
    apb_read(12'h004, rv); chk("R11 parity ignored", rv & 32'h0020_0000, 32'h0);
    apb_write(12'h000, 32'h0000_0700);
    pulse_parity();
    apb_read(12'h004, rv); chk("R7 R11 parity event", rv & 32'h0020_0000, 32'h0020_0000);

    // R9 soft register reset keeps FIFO
    eng_give(24'h0DDBA1, 1, 1);
    apb_write(12'h008, 32'h0010_0002);
    apb_write(12'h000, 32'hFFFF_FEFF);
    apb_read(12'h000, rv); chk("R9 ctrl", rv, 32'h0000_0500);
    apb_read(12'h008, rv); chk("R9 thr", rv, 32'h001C_0004);
    apb_read(12'h004, rv); chk("R9 evt", rv, 32'h0);
    apb_read(12'h00C, rv); chk("R9 level kept", rv & 32'h3F, 32'h1);
    host_take("R9 data kept");

    // R5 thresholds
    apb_write(12'h000, 32'h0000_1700);
    apb_write(12'h008, 32'h0004_0002);
    host_push(24'h000001, 1);
    host_push(24'h000002, 1);
    apb_read(12'h00C, rv); chk("R5 almost empty", rv, 32'h0200_0002);
    host_push(24'h000003, 1);
    host_push(24'h000004, 1);
    apb_read(12'h00C, rv); chk("R5 almost full", rv, 32'h0800_0004);
    for (int i = 0; i < 4; i++) eng_take("R5 drain");

    done = 1;
    summary();
    $finish;
  end
endmodule